// File: doc/BRIEF.md
# Load/store-multiple transfer sequencer

This block drives the memory side of a processor's block-transfer instruction, which moves a selected set of registers between the register file and consecutive memory words. One start pulse brings in a 16-bit selection mask, a base address and five control bits: pre/post indexing, count up/down, base write-back, load/store and user-bank select. The sequencer then makes one memory transfer per cycle, from the lowest selected register to the highest. It also tells the register file when to write the updated base.

The register file, memory and status logic are outside the block. It reads store data through a combinational register read port and returns load data through a write port that lags the transfer by one cycle. The base write goes through a port of its own. The sequence ends with a one-cycle `done` pulse. `abort_trap` rises with `done` when any transfer was refused by the memory system.

The instruction's first cycle is the start cycle, in which the addresses are computed. Transfers fill cycles 2 to n+1, where n is the number of selected registers. Cycle n+2 carries `done`.

Top module: `ldm_stm_seq`

## Requirements
- R1: Selected registers are transferred in ascending index order, one per cycle, starting in the cycle after start. `rf_rd_idx` names the register of the current transfer, and `mem_we` is 1 for a store and 0 for a load.
- R2: Let n be the number of set mask bits and B the base. The first address is B (count up, post-index), B+4 (count up, pre-index), B−4n+4 (count down, post-index) or B−4n (count down, pre-index). Each later transfer adds 4, so the lowest register always gets the lowest address.
- R3: With write-back set, `base_wr_en` pulses during the first transfer cycle with B+4n (count up) or B−4n (count down).
- R4: With write-back clear and no load into the base register, the base register keeps its value.
- R5: On a store, the base register holds its old value if it is the first register stored, and its updated value if it is stored later.
- R6: On a load, the register write for a transfer comes one cycle after it. A loaded base register therefore ends with the loaded value, not the write-back value.
- R7: Storing register 15 puts `inst_addr` + 12 on `mem_wdata`.
- R8: When a store transfer is aborted, all remaining transfers still take place. `abort_trap` is raised with `done`, and the write-back base is kept.
- R9: When a load transfer is aborted, neither that register nor any later one is written. In the `done` cycle the base is rewritten with B±4n if write-back was requested, and with B otherwise. `abort_trap` is raised with `done`.
- R10: `rf_user` is high during the sequence when the user-bank bit is set and either register 15 is not selected or the operation is a store. It is low otherwise.
- R11: A load with the user-bank bit set and register 15 selected pulses `psr_restore` in the cycle that register 15 is written. That is the `done` cycle.
- R12: An all-zero mask raises `done` in the cycle after start. It makes no memory transfer and no register or base write.
- R13: After reset, `busy`, `mem_req` and `done` are 0. For a mask with n set bits, `done` is a single pulse in cycle n+2, and `busy` is high from cycle 2 through cycle n+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a sequence; sampled only while idle |
| reg_mask | input | 16 | Register selection, bit i = register i |
| base_in | input | 32 | Base address value |
| inst_addr | input | 32 | Address of the instruction, used for the register 15 store value |
| pre_index | input | 1 | 1: offset applied before each transfer |
| count_up | input | 1 | 1: addresses above base; 0: below |
| write_back | input | 1 | 1: write the updated base |
| is_load | input | 1 | 1: load; 0: store |
| user_sel | input | 1 | User-bank / status-restore select bit |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory transfer this cycle |
| mem_we | output | 1 | 1: write transfer |
| mem_addr | output | 32 | Word address of the transfer |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid in the request cycle |
| mem_abort | input | 1 | Memory refuses the current transfer |
| rf_rd_idx | output | 4 | Register read index for the current transfer |
| rf_rd_data | input | 32 | Register read data (combinational) |
| rf_user | output | 1 | Register accesses target the user bank |
| rf_wr_en | output | 1 | Register write enable for loaded data |
| rf_wr_idx | output | 4 | Register write index |
| rf_wr_data | output | 32 | Register write data |
| base_wr_en | output | 1 | Base register write enable |
| base_wr_data | output | 32 | Base register write value |
| psr_restore | output | 1 | Copy saved status into current status |
| done | output | 1 | Sequence finished (one cycle) |
| abort_trap | output | 1 | An abort occurred during the finished sequence |

## Verification
The assertions assume three things about the environment. `start` is raised only while `busy` is low. The memory answers and signals an abort in the same cycle as the request. `rf_rd_data` follows `rf_rd_idx` combinationally. The bench model meets all three. It pulses `start` once per operation and waits for `done` plus one idle cycle. The same process that samples the outputs at the falling edge also serves reads from its arrays and applies writes. The stimulus never selects register 15 as the base and never combines write-back with user-bank transfers, because the behaviour of the block is not defined for those cases.

// File: rtl/ldm_seq_pkg.sv
// Package: shared types for the load/store-multiple sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package ldm_seq_pkg;

    // Sequencer phase: idle/address setup, transfer, finish.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/ldm_addr_plan.sv
// Module: ldm_addr_plan
// Does: counts the selected registers and derives the lowest transfer
//       address and the written-back base from the indexing mode.
// Assumes: purely combinational; mask may be empty (count zero).
module ldm_addr_plan #(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int CW        = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] mask,
    input  logic [AW-1:0]   base,
    input  logic            pre_index,
    input  logic            count_up,
    output logic [CW-1:0]   count,
    output logic [AW-1:0]   lowest_addr,
    output logic [AW-1:0]   final_base
);

    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] span;

    // Population count of the selection mask.
    always_comb begin
        count = '0;
        for (int i = 0; i < NREG; i++) begin
            count = count + CW'(mask[i]);
        end
    end

    // Lowest address and final base for the four indexing modes.
    always_comb begin
        span = AW'(count) * STEP;
        unique case ({count_up, pre_index})
            2'b10:   lowest_addr = base;
            2'b11:   lowest_addr = base + STEP;
            2'b00:   lowest_addr = base - span + STEP;
            default: lowest_addr = base - span;
        endcase
        final_base = count_up ? (base + span) : (base - span);
    end

endmodule

// File: rtl/ldm_mask_walk.sv
// Module: ldm_mask_walk
// Does: picks the lowest set bit of the remaining mask and gives the mask
//       with that bit cleared, plus a flag for the final transfer.
// Assumes: combinational; an empty mask yields index zero and last=1.
module ldm_mask_walk #(
    parameter int NREG = 16,
    localparam int IW  = $clog2(NREG)
) (
    input  logic [NREG-1:0] remaining,
    output logic [IW-1:0]   cur_idx,
    output logic [NREG-1:0] next_remaining,
    output logic            is_last
);

    // Priority encode toward the lowest index.
    always_comb begin
        cur_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (remaining[i]) cur_idx = IW'(i);
        end
    end

    // Clear the lowest set bit and flag the end of the list.
    always_comb begin
        next_remaining = remaining & (remaining - NREG'(1));
        is_last        = (next_remaining == '0);
    end

endmodule

// File: rtl/ldm_resp_stage.sv
// Module: ldm_resp_stage
// Does: holds load data for one cycle before the register write, and
//       remembers whether any transfer of the current sequence aborted.
//       Once an abort is seen, no further register write is issued.
// Assumes: clear and xfer are never high in the same cycle.
module ldm_resp_stage #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          xfer,
    input  logic          load,
    input  logic [IW-1:0] idx_in,
    input  logic [DW-1:0] data_in,
    input  logic          abort_in,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [DW-1:0] wr_data,
    output logic          abort_seen
);

    // Register the load response and suppress it after any abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en      <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
            abort_seen <= 1'b0;
        end else begin
            wr_en <= xfer && load && !abort_in && !abort_seen;
            if (xfer) begin
                wr_idx  <= idx_in;
                wr_data <= data_in;
            end
            if (clear) abort_seen <= 1'b0;
            else if (xfer && abort_in) abort_seen <= 1'b1;
        end
    end

    // R9: after an abort has been seen, the next cycle carries no write.
    p_suppress_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_seen && !clear) |=> !wr_en);

    // R9: an aborted transfer never produces a register write.
    p_abort_nowr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && abort_in) |=> !wr_en);

endmodule

// File: rtl/ldm_stm_seq.sv
// Module: ldm_stm_seq (top)
// Does: sequences a load/store-multiple instruction. The start cycle sets up
//       addresses, then one transfer per cycle in ascending register order,
//       then a finish cycle with done. Base write-back is issued in the first
//       transfer cycle. A load abort stops register writes and restores the
//       base in the finish cycle.
// Assumes: start only while idle; memory answers (data/abort) in the request
//          cycle; rf_rd_data follows rf_rd_idx combinationally.
module ldm_stm_seq #(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int WORD_BYTES = 4,
    parameter int PC_OFFSET  = 12,
    localparam int IW        = $clog2(NREG),
    localparam int CW        = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NREG-1:0] reg_mask,
    input  logic [AW-1:0]   base_in,
    input  logic [AW-1:0]   inst_addr,
    input  logic            pre_index,
    input  logic            count_up,
    input  logic            write_back,
    input  logic            is_load,
    input  logic            user_sel,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    input  logic            mem_abort,
    output logic [IW-1:0]   rf_rd_idx,
    input  logic [DW-1:0]   rf_rd_data,
    output logic            rf_user,
    output logic            rf_wr_en,
    output logic [IW-1:0]   rf_wr_idx,
    output logic [DW-1:0]   rf_wr_data,
    output logic            base_wr_en,
    output logic [AW-1:0]   base_wr_data,
    output logic            psr_restore,
    output logic            done,
    output logic            abort_trap
);

    import ldm_seq_pkg::*;

    localparam logic [AW-1:0] STEP   = AW'(WORD_BYTES);
    localparam logic [IW-1:0] PC_IDX = IW'(NREG - 1);

    seq_state_t      state;
    logic [NREG-1:0] rem_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   newb_q;
    logic [AW-1:0]   origb_q;
    logic [AW-1:0]   inst_q;
    logic            load_q;
    logic            wb_q;
    logic            usr_q;
    logic            pcl_q;
    logic            first_q;

    logic            accept;
    logic            xfer;
    logic [CW-1:0]   plan_count;
    logic [AW-1:0]   plan_low;
    logic [AW-1:0]   plan_final;
    logic [IW-1:0]   cur_idx;
    logic [NREG-1:0] next_rem;
    logic            is_last;
    logic            abort_seen;

    ldm_addr_plan #(
        .NREG(NREG), .AW(AW), .WORD_BYTES(WORD_BYTES)
    ) u_plan (
        .mask        (reg_mask),
        .base        (base_in),
        .pre_index   (pre_index),
        .count_up    (count_up),
        .count       (plan_count),
        .lowest_addr (plan_low),
        .final_base  (plan_final)
    );

    ldm_mask_walk #(.NREG(NREG)) u_walk (
        .remaining      (rem_q),
        .cur_idx        (cur_idx),
        .next_remaining (next_rem),
        .is_last        (is_last)
    );

    ldm_resp_stage #(.NREG(NREG), .DW(DW)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .xfer       (xfer),
        .load       (load_q),
        .idx_in     (cur_idx),
        .data_in    (mem_rdata),
        .abort_in   (mem_abort),
        .wr_en      (rf_wr_en),
        .wr_idx     (rf_wr_idx),
        .wr_data    (rf_wr_data),
        .abort_seen (abort_seen)
    );

    // Phase decode shared by the output logic.
    always_comb begin
        accept = (state == ST_IDLE) && start;
        xfer   = (state == ST_XFER);
        busy   = (state != ST_IDLE);
        done   = (state == ST_FIN);
    end

    // Sequencer state and per-instruction context registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rem_q   <= '0;
            addr_q  <= '0;
            newb_q  <= '0;
            origb_q <= '0;
            inst_q  <= '0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
            usr_q   <= 1'b0;
            pcl_q   <= 1'b0;
            first_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        rem_q   <= reg_mask;
                        addr_q  <= plan_low;
                        newb_q  <= plan_final;
                        origb_q <= base_in;
                        inst_q  <= inst_addr;
                        load_q  <= is_load;
                        wb_q    <= write_back && (plan_count != '0);
                        usr_q   <= user_sel && (!reg_mask[NREG-1] || !is_load);
                        pcl_q   <= user_sel && reg_mask[NREG-1] && is_load;
                        first_q <= 1'b1;
                        state   <= (reg_mask == '0) ? ST_FIN : ST_XFER;
                    end
                end
                ST_XFER: begin
                    addr_q  <= addr_q + STEP;
                    rem_q   <= next_rem;
                    first_q <= 1'b0;
                    if (is_last) state <= ST_FIN;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Memory request, address and store data selection.
    always_comb begin
        mem_req   = xfer;
        mem_we    = xfer && !load_q;
        mem_addr  = addr_q;
        rf_rd_idx = cur_idx;
        if (xfer && !load_q) begin
            mem_wdata = (cur_idx == PC_IDX) ? DW'(inst_q + AW'(PC_OFFSET))
                                            : rf_rd_data;
        end else begin
            mem_wdata = '0;
        end
    end

    // Base write-back, abort restore, bank select, status restore, trap.
    always_comb begin
        base_wr_en   = (xfer && first_q && wb_q) || (done && load_q && abort_seen);
        base_wr_data = (xfer || wb_q) ? newb_q : origb_q;
        rf_user      = usr_q && busy;
        psr_restore  = pcl_q && rf_wr_en && (rf_wr_idx == PC_IDX);
        abort_trap   = done && abort_seen;
    end

    // R2: consecutive transfers step the address by one word.
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + STEP));

    // R1: consecutive transfers use strictly rising register indices.
    p_idx_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> (rf_rd_idx > $past(rf_rd_idx)));

    // R3: a write-back during transfers happens only in the first one.
    p_wb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && base_wr_en) |-> !$past(mem_req));

    // R11: status restore coincides with the end of the sequence.
    p_psr_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        psr_restore |-> done);

    // R12: an empty mask finishes next cycle with no transfer.
    p_empty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (reg_mask == '0)) |=> (done && !mem_req && !rf_wr_en));

    // R13: done is a single pulse followed by idle.
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R13: no transfer and done together.
    p_req_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && done));

endmodule

// File: tb/sim_ldm_stm_seq.sv
module sim_ldm_stm_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] reg_mask = '0;
    logic [31:0] base_in = '0;
    logic [31:0] inst_addr = '0;
    logic        pre_index = 1'b0, count_up = 1'b0, write_back = 1'b0;
    logic        is_load = 1'b0, user_sel = 1'b0;
    logic        busy, mem_req, mem_we, mem_abort, rf_user, rf_wr_en;
    logic        base_wr_en, psr_restore, done, abort_trap;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rd_data, rf_wr_data, base_wr_data;
    logic [3:0]  rf_rd_idx, rf_wr_idx;

    logic [31:0] bank [16];
    logic [31:0] ubank [16];
    logic [31:0] mem [256];
    logic        ab_on = 1'b0;
    logic [31:0] ab_addr = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int bidx    = 9;

    // per-operation log
    logic [31:0] lg_addr [16];
    logic [3:0]  lg_idx [16];
    logic        lg_we [16];
    logic        lg_usr [16];
    int          nx, ncyc, wb_at, psr_cnt, wr_cnt;
    logic        saw_trap, end_usr;

    always #5 clk = ~clk;

    assign mem_rdata  = mem[mem_addr[9:2]];
    assign rf_rd_data = rf_user ? ubank[rf_rd_idx] : bank[rf_rd_idx];
    assign mem_abort  = ab_on && mem_req && (mem_addr == ab_addr);

    ldm_stm_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_mask(reg_mask),
        .base_in(base_in), .inst_addr(inst_addr), .pre_index(pre_index),
        .count_up(count_up), .write_back(write_back), .is_load(is_load),
        .user_sel(user_sel), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_abort(mem_abort), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_user(rf_user), .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx),
        .rf_wr_data(rf_wr_data), .base_wr_en(base_wr_en),
        .base_wr_data(base_wr_data), .psr_restore(psr_restore), .done(done),
        .abort_trap(abort_trap)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic preset_regs();
        for (int i = 0; i < 16; i++) begin
            bank[i]  = 32'hA000_0000 + 32'(i);
            ubank[i] = 32'hB000_0000 + 32'(i);
        end
    endtask

    // Sample outputs at the falling edge and apply memory/register writes.
    task automatic sample_apply();
        if (mem_req) begin
            lg_addr[nx] = mem_addr;
            lg_idx[nx]  = rf_rd_idx;
            lg_we[nx]   = mem_we;
            lg_usr[nx]  = rf_user;
            if (mem_we && !mem_abort) mem[mem_addr[9:2]] = mem_wdata;
            nx++;
        end
        if (base_wr_en) begin
            bank[bidx] = base_wr_data;
            if (wb_at < 0) wb_at = ncyc;
        end
        if (rf_wr_en) begin
            wr_cnt++;
            if (rf_user) ubank[rf_wr_idx] = rf_wr_data;
            else         bank[rf_wr_idx]  = rf_wr_data;
        end
        if (psr_restore) psr_cnt++;
        if (abort_trap) saw_trap = 1'b1;
    endtask

    task automatic run_op(input logic [15:0] m, input logic [31:0] b,
                          input bit pre, input bit up, input bit wb,
                          input bit ld, input bit s, input logic [31:0] ia);
        nx = 0; ncyc = 0; wb_at = -1; psr_cnt = 0; wr_cnt = 0;
        saw_trap = 1'b0; end_usr = 1'b0;
        @(negedge clk);
        reg_mask = m; base_in = b; pre_index = pre; count_up = up;
        write_back = wb; is_load = ld; user_sel = s; inst_addr = ia;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ncyc = 1;
        while (ncyc < 64) begin
            sample_apply();
            if (done) begin
                end_usr = rf_user;
                break;
            end
            @(negedge clk);
            ncyc++;
        end
        @(negedge clk);
    endtask

    function automatic int popc(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    // Table: mask, base, pre, up, wb, expected first address, expected base after
    localparam int NV = 6;
    localparam logic [15:0] V_MASK [NV] = '{16'h00A2, 16'h00A2, 16'h00A2, 16'h00A2, 16'h0011, 16'h7000};
    localparam logic [31:0] V_BASE [NV] = '{32'h1000, 32'h1000, 32'h1000, 32'h1000, 32'h1000, 32'h1040};
    localparam bit          V_PRE  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam bit          V_UP   [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam bit          V_WB   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [31:0] V_LOW  [NV] = '{32'h1000, 32'h1004, 32'h0FF8, 32'h0FF4, 32'h1004, 32'h1038};
    localparam logic [31:0] V_FIN  [NV] = '{32'h100C, 32'h100C, 32'h0FF4, 32'h0FF4, 32'h1000, 32'h1034};

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd20000, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 256; i++) mem[i] = 32'hC000_0000 + 32'(i);
        preset_regs();
        repeat (3) @(negedge clk);
        // R13: reset state
        chk(!busy && !mem_req && !done, "R13 reset", {busy, mem_req, done}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: stores, base in register 9
        for (int v = 0; v < NV; v++) begin
            int    n;
            bit    ok_ord, ok_addr, ok_mem;
            int    k;
            preset_regs();
            bidx = 9;
            bank[9] = V_BASE[v];
            run_op(V_MASK[v], V_BASE[v], V_PRE[v], V_UP[v], V_WB[v], 1'b0, 1'b0, 32'h0);
            n = popc(V_MASK[v]);
            chk(nx == n, "R1 transfer count", 32'(nx), 32'(n));
            chk(ncyc == n + 1, "R13 done cycle", 32'(ncyc), 32'(n + 1));
            ok_ord = 1'b1; ok_addr = 1'b1; ok_mem = 1'b1; k = 0;
            for (int i = 0; i < 16; i++) begin
                if (V_MASK[v][i] && k < nx) begin
                    if (lg_idx[k] != 4'(i) || !lg_we[k]) ok_ord = 1'b0;
                    if (lg_addr[k] != V_LOW[v] + 32'(4 * k)) ok_addr = 1'b0;
                    if (mem[lg_addr[k][9:2]] != 32'hA000_0000 + 32'(i)) ok_mem = 1'b0;
                    k++;
                end
            end
            chk(ok_ord, "R1 ascending order and store strobe", 32'(v), 32'(v));
            chk(ok_addr, "R2 address sequence", lg_addr[0], V_LOW[v]);
            chk(ok_mem, "R1 stored data", 32'(v), 32'(v));
            chk(bank[9] == V_FIN[v], V_WB[v] ? "R3 written-back base" : "R4 base kept",
                bank[9], V_FIN[v]);
            if (V_WB[v]) chk(wb_at == 1, "R3 write-back in first transfer", 32'(wb_at), 32'd1);
        end

        // R5: base stored first -> old value
        preset_regs();
        bidx = 2; bank[2] = 32'h1000;
        run_op(16'h0204, 32'h1000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
        chk(mem[32'h1000 >> 2 & 255] == 32'h1000, "R5 base first stores old",
            mem[32'h1000 >> 2 & 255], 32'h1000);
        // R5: base stored second -> updated value
        preset_regs();
        bidx = 9; bank[9] = 32'h1100;
        run_op(16'h0204, 32'h1100, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
        chk(mem[(32'h1104 >> 2) & 255] == 32'h1108, "R5 base later stores updated",
            mem[(32'h1104 >> 2) & 255], 32'h1108);

        // R7: register 15 store value
        preset_regs();
        bidx = 9; bank[9] = 32'h1000;
        run_op(16'h8001, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h2000);
        chk(mem[(32'h1004 >> 2) & 255] == 32'h200C, "R7 pc store value",
            mem[(32'h1004 >> 2) & 255], 32'h200C);

        // R6: load including base with write-back
        preset_regs();
        bidx = 3; bank[3] = 32'h1000;
        mem[(32'h1000 >> 2) & 255] = 32'h5555_0000;
        mem[(32'h1004 >> 2) & 255] = 32'h6666_0000;
        run_op(16'h0018, 32'h1000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0);
        chk(bank[3] == 32'h5555_0000, "R6 load overwrites base", bank[3], 32'h5555_0000);
        chk(bank[4] == 32'h6666_0000, "R6 load second register", bank[4], 32'h6666_0000);
        chk(!lg_we[0] && !lg_we[1], "R1 load strobe low", {31'd0, lg_we[0]}, 32'h0);

        // R8: store abort at second transfer
        preset_regs();
        bidx = 9; bank[9] = 32'h1000;
        ab_on = 1'b1; ab_addr = 32'h1004;
        run_op(16'h000E, 32'h1000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0);
        ab_on = 1'b0;
        chk(nx == 3, "R8 store continues after abort", 32'(nx), 32'd3);
        chk(saw_trap, "R8 abort trap", {31'd0, saw_trap}, 32'h1);
        chk(bank[9] == 32'h100C, "R8 base keeps write-back", bank[9], 32'h100C);

        // R9: load abort, no write-back, base in list before abort
        preset_regs();
        bidx = 3; bank[3] = 32'h1000;
        mem[(32'h1000 >> 2) & 255] = 32'h7777_0000;
        ab_on = 1'b1; ab_addr = 32'h1004;
        run_op(16'h00E8, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0);
        ab_on = 1'b0;
        chk(bank[3] == 32'h1000, "R9 base restored original", bank[3], 32'h1000);
        chk(bank[5] == 32'hA000_0005 && bank[6] == 32'hA000_0006 && bank[7] == 32'hA000_0007,
            "R9 later loads suppressed", bank[7], 32'hA000_0007);
        chk(saw_trap && nx == 4, "R9 trap after all transfers", 32'(nx), 32'd4);

        // R9: load abort at last transfer, with write-back
        preset_regs();
        bidx = 3; bank[3] = 32'h1000;
        ab_on = 1'b1; ab_addr = 32'h100C;
        run_op(16'h00E8, 32'h1000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0);
        ab_on = 1'b0;
        chk(bank[3] == 32'h1010, "R9 base restored modified", bank[3], 32'h1010);
        chk(bank[7] == 32'hA000_0007, "R9 aborting load not written", bank[7], 32'hA000_0007);
        chk(bank[6] == mem[(32'h1008 >> 2) & 255], "R9 earlier load kept", bank[6],
            mem[(32'h1008 >> 2) & 255]);

        // R10: user bank on store without register 15
        preset_regs();
        bidx = 9; bank[9] = 32'h1000;
        run_op(16'h0003, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0);
        chk(lg_usr[0] && lg_usr[1], "R10 user bank flag", {31'd0, lg_usr[0]}, 32'h1);
        chk(mem[(32'h1004 >> 2) & 255] == 32'hB000_0001, "R10 user bank data",
            mem[(32'h1004 >> 2) & 255], 32'hB000_0001);

        // R10/R11: load with register 15 and user bit: status restore, current bank
        preset_regs();
        bidx = 9; bank[9] = 32'h1000;
        mem[(32'h1000 >> 2) & 255] = 32'h0000_4000;
        run_op(16'h8000, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0);
        chk(!lg_usr[0] && !end_usr, "R10 no user bank with pc load", {31'd0, lg_usr[0]}, 32'h0);
        chk(psr_cnt == 1, "R11 status restore pulse", 32'(psr_cnt), 32'd1);
        chk(bank[15] == 32'h0000_4000, "R11 pc loaded", bank[15], 32'h0000_4000);

        // R11: no restore without user bit
        run_op(16'h8000, 32'h1000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0);
        chk(psr_cnt == 0, "R11 no restore without user bit", 32'(psr_cnt), 32'd0);

        // R12: empty mask
        preset_regs();
        bidx = 9; bank[9] = 32'h1000;
        run_op(16'h0000, 32'h1000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0);
        chk(ncyc == 1 && nx == 0, "R12 empty mask done next cycle", 32'(ncyc), 32'd1);
        chk(wr_cnt == 0 && wb_at < 0 && bank[9] == 32'h1000, "R12 no writes",
            bank[9], 32'h1000);
        chk(!busy && !done, "R13 idle after done", {busy, done}, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule